// File: doc/BRIEF.md
# Two-Pass Row/Column Transform Sequencer

This controller turns an external one-dimensional transform engine into a two-dimensional one. An image of N by N samples sits in an image RAM. The controller works through it one row at a time. For each row it starts the engine, streams the row's samples into it and waits for the engine's early-done flag. It then requests the results and stores each result sample in a separate transpose RAM. The sample's output index selects the row and the current row number selects the column, so the row lands as a column. A second pass reads the transpose RAM row by row and stores its results back into the image RAM in the same transposed way. The image therefore ends up in its original orientation with both dimensions transformed.

Two image banks are handled in one run. Bank 0 goes through both passes, then bank 1 goes through the same sequence. A one-cycle completion pulse follows the last write. The direction bit sampled at the start of a run selects a forward or an inverse transform for the whole run. No sample data passes through the controller: it drives only the engine handshake, the active-low RAM enables, an active-low write strobe and a shared row/column address bus.

Top module: `tx2d_seq`

## Requirements
- R1: While `rst` (active high) is asserted, and in idle, the outputs are as follows: all RAM enables `img_en_n` and `xp_en_n` are high (inactive), `wr_n` is high, `eng_start`, `eng_unload` and `done` are low, `eng_fwd` is 0, `eng_scale` is 0 and `eng_rst` is 1.
- R2: When `go` is sampled high in idle, `eng_start` is high for exactly one cycle in the next cycle and `eng_rst` drops.
- R3: While loading a row, the controller issues a read only in a cycle where `eng_rfd` is high. It issues exactly N reads, at row address equal to the current row and column addresses 0,1,..,N-1 in order. It stays in the loading phase until `eng_edone` is high.
- R4: `eng_unload` is high for exactly one cycle, the cycle after the one in which `eng_edone` was seen while loading, and at no other time.
- R5: Each cycle with `eng_dv` high during unloading produces one write (`wr_n` low) with row address equal to `eng_idx` and column address equal to the current row.
- R6: In pass 0, reads use the current image bank and writes use the transpose RAM. In pass 1, reads use the transpose RAM and writes use the current image bank. At most one RAM enable is low in any cycle.
- R7: A row ends on the write whose `eng_idx` equals N-1. After N rows the pass changes, and after both passes of bank 0 the same sequence runs for bank 1. A run therefore holds 4N engine starts.
- R8: For the whole run, `eng_fwd` equals the `dir` value sampled with `go` (1 forward, 0 inverse), and `eng_scale` equals the SCALE_SCHED parameter (default 6'h16 for N=8).
- R9: `done` is a one-cycle pulse. It appears in the cycle after the final write of pass 1 of the last bank. The controller then returns to idle and accepts `go` again.
- R10: `go` and `dir` have no effect while a run is in progress: the run keeps its start count, its direction and its single `done`.
- R11: The stored result follows the engine's index order, whatever order the engine uses (natural or bit-reversed), as long as index N-1 comes last. The sequence as a whole leaves each image element at its original position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Starts a run when idle |
| dir | input | 1 | Direction, sampled with go: 1 forward, 0 inverse |
| eng_start | output | 1 | Engine start pulse |
| eng_unload | output | 1 | Engine result-unload request |
| eng_fwd | output | 1 | Engine direction select |
| eng_rst | output | 1 | Engine reset, high while idle |
| eng_scale | output | 2*log2(N) | Engine scaling setting |
| eng_rfd | input | 1 | Engine ready for data |
| eng_edone | input | 1 | Engine early-done flag |
| eng_dv | input | 1 | Engine output sample valid |
| eng_idx | input | log2(N) | Index of the engine output sample |
| img_en_n | output | NIMG | Image bank enables, active low |
| xp_en_n | output | 1 | Transpose RAM enable, active low |
| wr_n | output | 1 | Write strobe, active low |
| row_addr | output | log2(N) | Row address |
| col_addr | output | log2(N) | Column address |
| done | output | 1 | Run complete pulse |

## Verification
The start pulse is due one cycle after `go` is sampled, and the unload pulse one cycle after the early-done flag. Each read or write acts in the same cycle as the engine's ready or valid signal, and `done` follows one cycle after the final write. The bench's engine model samples the outputs a short delay after the falling edge, once its own inputs for the coming edge are settled. Each observation therefore describes exactly what the next rising edge commits. The bench records cycle numbers of go, first start, last write and done, and compares their differences with these latencies.

// File: rtl/tx2d_pkg.sv
package tx2d_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_LOAD  = 3'd2,
    ST_UNLD  = 3'd3,
    ST_STORE = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic img_act;
    logic xp_act;
  } bank_t;

  // Pass 0 reads the image and writes the transpose RAM; pass 1 swaps them.
  function automatic bank_t pick_bank(input logic pass, input logic rd, input logic wr);
    bank_t b;
    b.img_act = pass ? wr : rd;
    b.xp_act  = pass ? rd : wr;
    return b;
  endfunction

  // Store address: engine index becomes the row, current row becomes the column.
  function automatic logic [15:0] xpose_pack(input logic [7:0] idx, input logic [7:0] row);
    return {idx, row};
  endfunction

endpackage

// File: rtl/tx2d_prog.sv
module tx2d_prog #(
  parameter int N    = 8,
  parameter int NIMG = 2,
  localparam int LG  = $clog2(N),
  localparam int IW  = (NIMG > 1) ? $clog2(NIMG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [LG-1:0] row,
  output logic          pass,
  output logic [IW-1:0] img,
  output logic          last_row,
  output logic          last_unit
);
  localparam logic [LG-1:0] ROW_LAST = LG'(N - 1);
  localparam logic [IW-1:0] IMG_LAST = IW'(NIMG - 1);

  assign last_row  = (row == ROW_LAST);
  assign last_unit = last_row && pass && (img == IMG_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row  <= '0;
      pass <= 1'b0;
      img  <= '0;
    end else if (adv) begin
      row <= last_row ? '0 : row + 1'b1;
      if (last_row) begin
        pass <= ~pass;
        if (pass) img <= (img == IMG_LAST) ? '0 : img + 1'b1;
      end
    end
  end

  assert_row_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && last_row) |=> (row == '0))
    else $error("row did not wrap");

  assert_pass_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && last_row) |=> (pass != $past(pass)))
    else $error("pass did not change");

endmodule

// File: rtl/tx2d_ctl.sv
module tx2d_ctl
  import tx2d_pkg::*;
#(
  parameter int N   = 8,
  localparam int LG = $clog2(N),
  localparam int CW = LG + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          eng_rfd,
  input  logic          eng_edone,
  input  logic          eng_dv,
  input  logic [LG-1:0] eng_idx,
  input  logic          last_unit,
  output seq_st_e       st,
  output logic [LG-1:0] rd_col,
  output logic          accept,
  output logic          rd_fire,
  output logic          wr_fire,
  output logic          row_end,
  output logic          run_end
);
  localparam logic [CW-1:0] CNT_FULL = CW'(N);
  localparam logic [LG-1:0] IDX_LAST = LG'(N - 1);

  seq_st_e       nxt;
  logic [CW-1:0] cnt;

  assign accept  = (st == ST_IDLE) && go;
  assign rd_fire = (st == ST_LOAD) && eng_rfd && (cnt < CNT_FULL);
  assign wr_fire = (st == ST_STORE) && eng_dv;
  assign row_end = wr_fire && (eng_idx == IDX_LAST);
  assign run_end = row_end && last_unit;
  assign rd_col  = cnt[LG-1:0];

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (go) nxt = ST_START;
      ST_START: nxt = ST_LOAD;
      ST_LOAD:  if (eng_edone) nxt = ST_UNLD;
      ST_UNLD:  nxt = ST_STORE;
      ST_STORE: if (row_end) nxt = last_unit ? ST_IDLE : ST_START;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (st == ST_START) cnt <= '0;
      else if (rd_fire)   cnt <= cnt + 1'b1;
    end
  end

  assert_read_needs_rfd_R3: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> eng_rfd)
    else $error("read without ready");

  assert_read_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |-> (cnt <= CNT_FULL))
    else $error("read count overrun");

  assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START) |=> (st == ST_LOAD))
    else $error("start held");

  assert_unload_after_edone_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD && eng_edone) |=> (st == ST_UNLD))
    else $error("no unload after early-done");

  assert_go_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_STORE) |=> (st != ST_IDLE))
    else $error("run left early");

endmodule

// File: rtl/tx2d_seq.sv
module tx2d_seq
  import tx2d_pkg::*;
#(
  parameter int N           = 8,
  parameter int NIMG        = 2,
  parameter int SCALE_SCHED = 'h16,
  localparam int LG         = $clog2(N),
  localparam int IW         = (NIMG > 1) ? $clog2(NIMG) : 1,
  localparam int SCW        = 2 * LG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            dir,
  output logic            eng_start,
  output logic            eng_unload,
  output logic            eng_fwd,
  output logic            eng_rst,
  output logic [SCW-1:0]  eng_scale,
  input  logic            eng_rfd,
  input  logic            eng_edone,
  input  logic            eng_dv,
  input  logic [LG-1:0]   eng_idx,
  output logic [NIMG-1:0] img_en_n,
  output logic            xp_en_n,
  output logic            wr_n,
  output logic [LG-1:0]   row_addr,
  output logic [LG-1:0]   col_addr,
  output logic            done
);
  seq_st_e       st;
  logic [LG-1:0] rd_col;
  logic          accept, rd_fire, wr_fire, row_end, run_end;
  logic [LG-1:0] row;
  logic          pass;
  logic [IW-1:0] img;
  logic          last_row, last_unit;
  logic          dir_q, done_q;
  bank_t         bank;
  logic          idle_now;

  tx2d_ctl #(.N(N)) u_ctl (
    .clk(clk), .rst(rst), .go(go), .eng_rfd(eng_rfd), .eng_edone(eng_edone),
    .eng_dv(eng_dv), .eng_idx(eng_idx), .last_unit(last_unit), .st(st),
    .rd_col(rd_col), .accept(accept), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .row_end(row_end), .run_end(run_end)
  );

  tx2d_prog #(.N(N), .NIMG(NIMG)) u_prog (
    .clk(clk), .rst(rst), .clr(accept), .adv(row_end), .row(row), .pass(pass),
    .img(img), .last_row(last_row), .last_unit(last_unit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (accept) dir_q <= dir;
      done_q <= run_end;
    end
  end

  assign idle_now   = (st == ST_IDLE);
  assign eng_start  = (st == ST_START);
  assign eng_unload = (st == ST_UNLD);
  assign eng_rst    = idle_now;
  assign eng_fwd    = !idle_now && dir_q;
  assign eng_scale  = idle_now ? '0 : SCW'(SCALE_SCHED);
  assign done       = done_q;

  assign bank    = pick_bank(pass, rd_fire, wr_fire);
  assign xp_en_n = ~bank.xp_act;
  assign wr_n    = ~wr_fire;

  for (genvar b = 0; b < NIMG; b++) begin : g_bank
    assign img_en_n[b] = ~(bank.img_act && (img == IW'(b)));
  end

  logic [15:0] st_addr;
  assign st_addr  = xpose_pack(8'(eng_idx), 8'(row));
  assign row_addr = wr_fire ? st_addr[8+LG-1:8] : row;
  assign col_addr = wr_fire ? st_addr[LG-1:0]   : rd_col;

  assert_one_bank_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({~img_en_n, ~xp_en_n}) <= 1)
    else $error("two banks enabled");

  assert_write_has_bank_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ($countones({~img_en_n, ~xp_en_n}) == 1))
    else $error("write without bank");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done longer than one cycle");

  assert_dir_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!idle_now && !$past(idle_now)) |-> $stable(eng_fwd))
    else $error("direction changed mid-run");

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    idle_now |-> (&img_en_n && xp_en_n && wr_n && !eng_unload))
    else $error("idle not quiet");

endmodule

// File: tb/sim_tx2d_seq.sv
`timescale 1ns/1ps
module sim_tx2d_seq;
  localparam int N   = 8;
  localparam int LG  = 3;
  localparam int LAT = 4;
  localparam int SCL = 'h16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, dir = 1'b0;
  logic eng_start, eng_unload, eng_fwd, eng_rst;
  logic [5:0] eng_scale;
  logic eng_rfd = 1'b0, eng_edone = 1'b0, eng_dv = 1'b0;
  logic [LG-1:0] eng_idx = '0;
  logic [1:0] img_en_n;
  logic xp_en_n, wr_n, done;
  logic [LG-1:0] row_addr, col_addr;

  always #2 clk = ~clk;

  tx2d_seq #(.N(N), .NIMG(2), .SCALE_SCHED(SCL)) u0 (
    .clk(clk), .rst(rst), .go(go), .dir(dir), .eng_start(eng_start),
    .eng_unload(eng_unload), .eng_fwd(eng_fwd), .eng_rst(eng_rst),
    .eng_scale(eng_scale), .eng_rfd(eng_rfd), .eng_edone(eng_edone),
    .eng_dv(eng_dv), .eng_idx(eng_idx), .img_en_n(img_en_n), .xp_en_n(xp_en_n),
    .wr_n(wr_n), .row_addr(row_addr), .col_addr(col_addr), .done(done)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int mem  [3][N][N];
  int orig [2][N][N];
  int buff [N];

  // engine model state
  int e_st = 0, e_cnt = 0, e_tmr = 0, e_k = 0, e_kadd = 0;
  int cur_row = 0, cur_pass = 0, cur_img = 0;
  bit rev_mode = 0, gap_mode = 0, ed_prev = 0;
  int job_dir = 0;
  int starts, unloads, writes, dones, first_start, last_wr, done_cyc;
  int rd_bad, rd_addr_bad, unl_bad, wr_addr_bad, bank_bad, fwd_bad, wr_miss;

  function automatic int ordmap(input int k);
    int r = 0;
    if (!rev_mode) return k;
    for (int b = 0; b < LG; b++) if (k[b]) r = r | (1 << (LG - 1 - b));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Engine stand-in: drive after the falling edge, then observe what the next rising edge commits.
  initial begin
    forever begin
      @(negedge clk);
      eng_rfd   = (e_st == 1) && (!gap_mode || (cyc % 3 != 0));
      eng_edone = (e_st == 2) && (e_tmr == 0);
      eng_dv    = (e_st == 4);
      eng_idx   = LG'(ordmap(e_k));
      #1;
      begin
        bit rd, wr;
        int bk;
        rd = !rst && wr_n && ((img_en_n != 2'b11) || !xp_en_n);
        wr = !rst && !wr_n;
        bk = !img_en_n[0] ? 0 : (!img_en_n[1] ? 1 : (!xp_en_n ? 2 : -1));
        if (eng_unload != ed_prev) unl_bad++;
        if (eng_unload) unloads++;
        if (eng_start) begin
          int u;
          starts++;
          if (starts == 1) first_start = cyc;
          u = starts - 1;
          cur_row = u % N; cur_pass = (u / N) % 2; cur_img = u / (2 * N);
          if (eng_fwd != job_dir[0] || eng_scale != 6'(SCL)) fwd_bad++;
          e_kadd = eng_fwd ? 3 : 5;
          e_st = 1; e_cnt = 0;
        end else if (e_st == 1) begin
          if (rd) begin
            if (!eng_rfd) rd_bad++;
            if (int'(col_addr) != e_cnt || int'(row_addr) != cur_row) rd_addr_bad++;
            if (bk != (cur_pass == 0 ? cur_img : 2)) bank_bad++;
            if (bk >= 0) buff[e_cnt] = mem[bk][row_addr][col_addr];
            e_cnt++;
            if (e_cnt == N) begin e_st = 2; e_tmr = LAT; end
          end
        end else if (e_st == 2) begin
          if (rd) rd_bad++;
          if (e_tmr == 0) e_st = 3; else e_tmr--;
        end else if (e_st == 3) begin
          if (eng_unload) begin e_st = 4; e_k = 0; end
        end else if (e_st == 4) begin
          int ix;
          ix = ordmap(e_k);
          if (wr) begin
            if (int'(row_addr) != ix || int'(col_addr) != cur_row) wr_addr_bad++;
            if (bk != (cur_pass == 0 ? 2 : cur_img)) bank_bad++;
            if (bk >= 0) mem[bk][row_addr][col_addr] = buff[ix] + e_kadd;
            writes++; last_wr = cyc;
          end else wr_miss++;
          e_k++;
          if (e_k == N) e_st = 0;
        end else if (rd || wr) rd_bad++;
        if (done) begin dones++; done_cyc = cyc; end
        ed_prev = eng_edone;
      end
    end
  end

  task automatic idle_checks(input string tag);
    @(negedge clk); #1;
    chk(img_en_n == 2'b11 && xp_en_n && wr_n, {"R1 enables ", tag}, {img_en_n, xp_en_n, wr_n}, 15);
    chk(!eng_start && !eng_unload && !done, {"R1 strobes ", tag}, {eng_start, eng_unload, done}, 0);
    chk(!eng_fwd && eng_scale == 6'd0, {"R1 dir/scale ", tag}, int'(eng_scale), 0);
    chk(eng_rst, {"R1 engine reset ", tag}, eng_rst, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    idle_checks("in reset");
    @(negedge clk); rst = 1'b0;
    idle_checks("after reset");
  endtask

  task automatic t_job(input bit d, input bit rv, input bit gp, input bit mid, input string tag);
    int go_cyc, bad0, bad1;
    starts = 0; unloads = 0; writes = 0; dones = 0; first_start = -1; last_wr = -1; done_cyc = -1;
    rd_bad = 0; rd_addr_bad = 0; unl_bad = 0; wr_addr_bad = 0; bank_bad = 0; fwd_bad = 0; wr_miss = 0;
    rev_mode = rv; gap_mode = gp; job_dir = int'(d);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        orig[0][r][c] = r * 16 + c + 1;
        orig[1][r][c] = 300 + r * 7 + c * 11;
        mem[0][r][c] = orig[0][r][c];
        mem[1][r][c] = orig[1][r][c];
        mem[2][r][c] = -1;
      end
    @(negedge clk); go = 1'b1; dir = d; go_cyc = cyc;
    @(negedge clk); go = 1'b0;
    #1;
    chk(!eng_rst, {"R2 engine reset released ", tag}, eng_rst, 0);
    for (int w = 0; w < 6000 && dones == 0; w++) begin
      @(negedge clk);
      if (mid && w == 300) begin go = 1'b1; dir = ~d; end
      else go = 1'b0;
    end
    go = 1'b0; dir = d;
    repeat (4) @(negedge clk);
    chk(dones == 1, {"R9 one done pulse ", tag}, dones, 1);
    chk(done_cyc == last_wr + 1, {"R9 done after last write ", tag}, done_cyc - last_wr, 1);
    chk(first_start - go_cyc == 1, {"R2 start latency ", tag}, first_start - go_cyc, 1);
    chk(rd_bad == 0 && rd_addr_bad == 0, {"R3 load reads ", tag}, rd_bad + rd_addr_bad, 0);
    chk(unl_bad == 0 && unloads == 4 * N, {"R4 unload timing ", tag}, unloads - 64 * unl_bad, 4 * N);
    chk(wr_addr_bad == 0 && wr_miss == 0, {"R5 store address ", tag}, wr_addr_bad + wr_miss, 0);
    chk(writes == 4 * N * N, {"R5 write count ", tag}, writes, 4 * N * N);
    chk(bank_bad == 0, {"R6 bank selection ", tag}, bank_bad, 0);
    chk(starts == 4 * N, {"R7 start count ", tag}, starts, 4 * N);
    chk(fwd_bad == 0, {"R8 direction and scale ", tag}, fwd_bad, 0);
    if (mid) chk(starts == 4 * N && dones == 1 && fwd_bad == 0, {"R10 go ignored mid-run ", tag},
                 starts, 4 * N);
    bad0 = 0; bad1 = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        if (mem[0][r][c] != orig[0][r][c] + (d ? 6 : 10)) bad0++;
        if (mem[1][r][c] != orig[1][r][c] + (d ? 6 : 10)) bad1++;
      end
    chk(bad0 == 0, {"R11 bank 0 contents ", tag}, bad0, 0);
    chk(bad1 == 0, {"R7 R11 bank 1 contents ", tag}, bad1, 0);
    idle_checks({"back to idle ", tag});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_job(1'b1, 1'b0, 1'b0, 1'b0, "fwd natural");
    t_job(1'b0, 1'b1, 1'b1, 1'b0, "inv bitrev gaps");
    t_job(1'b1, 1'b1, 1'b0, 1'b1, "fwd bitrev go mid-run");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule